// File: doc/BRIEF.md
# Auto-Reload Timer with PWM Output

This block is an 8-bit up-counter behind a 7-bit binary prescaler. The prescaler is fed either from the system clock or from an external clock pin. The external pin is resynchronised and edge-detected, so the whole block runs on one clock. When the counter steps past its top value it does not wrap to zero. It reloads from a programmable reload value, so the period is the distance from the reload value to the top, plus one. Every reload raises a sticky overflow flag, which can drive an interrupt line. A single PWM channel starts each period at a programmable polarity level and flips to the opposite level when the count reaches a duty compare value.

Software reaches the block through a small register port:

| Address | Register | Contents |
|---|---|---|
| 0 | control/status | see R1 |
| 1 | live count | read and write |
| 2 | reload value | |
| 3 | duty compare | |
| 4 | PWM config | bit 0 = polarity |

- Writes take effect on the clock edge where `bus_wr_i` is high.
- Reads are combinational on `bus_rdata_o`.
- The `bus_rd_i` strobe only marks a read that has side effects, which is the flag clear.

The PWM channel is a three-state machine:

- PWM_IDLE: after reset, output low.
- PWM_MARK: output equals the polarity bit.
- PWM_SPACE: output is the inverse of the polarity bit.

Its transitions are:

- ovf_to_mark: from any state on an overflow.
- hit_to_space: from PWM_MARK when a counting step lands on the compare value.
- Every other case holds the current state.

Top module: `art_pwm_timer`

## Requirements
- R1: After reset every register reads 00h, `pwm_o` is 0 and `irq_o` is 0. The control/status register at address 0 has these fields:
  - bit 0: overflow flag
  - bit 1: interrupt enable
  - bit 2: force-reload, write-only
  - bit 3: run enable
  - bits 6:4: divide code
  - bit 7: external clock select
- R2: Divide code n (0 to 7) makes the counter step once every 2^n prescaler input pulses. On the system clock, a start written at edge E gives steps at edges E+2^n, E+2·2^n, and so on.
- R3: Clock select 0 counts system clock cycles. Clock select 1 counts only external clock edges, so the count holds while the external pin is idle.
- R4: With the run enable at 0, neither the prescaler nor the count changes.
- R5: Writing 1 to bit 2 of the control/status register loads the reload value into the count and clears the prescaler, with no count step in that cycle. Bit 2 always reads 0.
- R6: A step from FFh loads the reload value, so with reload R the count cycles through R..FFh with period 256−R steps.
- R7: An overflow sets the flag. A strobed read of the control/status register clears the flag, unless an overflow happens in the same cycle. `irq_o` is the flag ANDed with the interrupt enable.
- R8: On overflow, `pwm_o` takes the polarity level (PWM config bit 0). It takes the inverse level from the step on which the count becomes equal to the compare value. If the compare value is not above the reload value, the output stays at the polarity level for the whole period. Before the first overflow after reset, `pwm_o` is 0.
- R9: A write to the count register (address 1) replaces the live count while the timer runs, and it wins over a step in the same cycle.
- R10: The external clock passes through a two-flop synchroniser. Each rising edge gives exactly one prescaler input pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ext_clk_i | input | 1 | external count clock, asynchronous |
| bus_addr_i | input | 3 | register address |
| bus_wr_i | input | 1 | register write strobe |
| bus_rd_i | input | 1 | read strobe with side effects |
| bus_wdata_i | input | 8 | write data |
| bus_rdata_o | output | 8 | read data for `bus_addr_i` |
| irq_o | output | 1 | overflow interrupt |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its default 8-bit counter and 7-bit prescaler. Those defaults are small enough to step through all eight divide codes against several reload values, including the 1-step period at FFh. They also make it possible to check every cycle against the count predicted from the reload and the step index. The PWM output is swept over compare values below, at, just above and far above the reload, for both polarities. Overflow and read are made to coincide on a known edge, and the external-clock path is driven with counted pulses at two divide codes.

// File: rtl/art_pkg.sv
package art_pkg;

    typedef enum logic [1:0] {
        PWM_IDLE  = 2'd0,
        PWM_MARK  = 2'd1,
        PWM_SPACE = 2'd2
    } pwm_state_e;

    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] ADDR_CSR = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CNT = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_ARR = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_CMP = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADDR_CFG = 3'd4;

    // control/status field positions
    localparam int CSR_FLAG  = 0;
    localparam int CSR_IE    = 1;
    localparam int CSR_FORCE = 2;
    localparam int CSR_RUN   = 3;
    localparam int CSR_CODE  = 4;
    localparam int CSR_EXT   = 7;

endpackage

// File: rtl/art_tick_gen.sv
module art_tick_gen #(
    parameter int PRE_W  = 7,
    parameter int CODE_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_clk_i,
    input  logic              sel_ext_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              run_i,
    input  logic              clear_i,
    output logic              tick_o
);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              ext_pulse;
    logic              in_pulse;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  mask;

    // two-or-more flop synchroniser followed by a rising-edge detector
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_clk_i};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign ext_pulse = sync_q[SYNC_N-1] & ~prev_q;
    assign in_pulse  = sel_ext_i ? ext_pulse : 1'b1;

    // low code_i bits of the mask are ones
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(code_i));
        end
    end

    assign tick_o = run_i & in_pulse & ~clear_i & ((pre_q & mask) == mask);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (clear_i) begin
            pre_q <= '0;
        end else if (run_i && in_pulse) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    p_pre_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (pre_q == '0));

    p_pre_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clear_i) |=> $stable(pre_q));

    p_ext_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_pulse |=> !ext_pulse);

endmodule

// File: rtl/art_counter.sv
module art_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_o,
    output logic         step_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // a software write or a forced reload overrides a step
    assign step_o = tick_i & ~wr_i & ~load_i;
    assign ovf_o  = step_o & (cnt_q == CNT_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (wr_i) begin
            cnt_d = wr_data_i;
        end else if (load_i) begin
            cnt_d = reload_i;
        end else if (tick_i) begin
            cnt_d = (cnt_q == CNT_MAX) ? reload_i : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    p_wrap_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cnt_q == CNT_MAX && !wr_i && !load_i) |=> (cnt_q == $past(reload_i)));

    p_sw_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (cnt_q == $past(wr_data_i)));

    p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/art_pwm_fsm.sv
module art_pwm_fsm
    import art_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic         ovf_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         pol_i,
    output logic         pwm_o
);

    pwm_state_e   state_q;
    pwm_state_e   state_d;
    logic [W-1:0] cnt_inc;
    logic         hit;

    assign cnt_inc = cnt_i + 1'b1;
    assign hit     = step_i & ~ovf_i & (cnt_inc == cmp_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWM_IDLE:  if (ovf_i) state_d = PWM_MARK;
            PWM_MARK:  if (ovf_i) state_d = PWM_MARK;
                       else if (hit) state_d = PWM_SPACE;
            PWM_SPACE: if (ovf_i) state_d = PWM_MARK;
            default:   state_d = PWM_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PWM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PWM_IDLE:  pwm_o = 1'b0;
            PWM_MARK:  pwm_o = pol_i;
            PWM_SPACE: pwm_o = ~pol_i;
            default:   pwm_o = 1'b0;
        endcase
    end

    p_mark_on_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i |=> (state_q == PWM_MARK));

    p_no_return_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != PWM_IDLE) |=> (state_q != PWM_IDLE));

    p_space_from_mark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PWM_IDLE && !ovf_i) |=> (state_q == PWM_IDLE));

endmodule

// File: rtl/art_pwm_timer.sv
module art_pwm_timer
    import art_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 7,
    parameter int CODE_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ext_clk_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [CNT_W-1:0]      bus_wdata_i,
    output logic [CNT_W-1:0]      bus_rdata_o,
    output logic                  irq_o,
    output logic                  pwm_o
);

    logic              ext_sel_q;
    logic [CODE_W-1:0] code_q;
    logic              run_q;
    logic              ie_q;
    logic              flag_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              pol_q;

    logic              csr_wr;
    logic              csr_rd;
    logic              force_ld;
    logic              cnt_wr;
    logic              tick;
    logic              step;
    logic              ovf;
    logic [CNT_W-1:0]  cnt;

    assign csr_wr   = bus_wr_i & (bus_addr_i == ADDR_CSR);
    assign csr_rd   = bus_rd_i & (bus_addr_i == ADDR_CSR);
    assign force_ld = csr_wr & bus_wdata_i[CSR_FORCE];
    assign cnt_wr   = bus_wr_i & (bus_addr_i == ADDR_CNT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ext_sel_q <= 1'b0;
            code_q    <= '0;
            run_q     <= 1'b0;
            ie_q      <= 1'b0;
            reload_q  <= '0;
            cmp_q     <= '0;
            pol_q     <= 1'b0;
        end else if (bus_wr_i) begin
            unique case (bus_addr_i)
                ADDR_CSR: begin
                    ext_sel_q <= bus_wdata_i[CSR_EXT];
                    code_q    <= bus_wdata_i[CSR_CODE +: CODE_W];
                    run_q     <= bus_wdata_i[CSR_RUN];
                    ie_q      <= bus_wdata_i[CSR_IE];
                end
                ADDR_ARR: reload_q <= bus_wdata_i;
                ADDR_CMP: cmp_q    <= bus_wdata_i;
                ADDR_CFG: pol_q    <= bus_wdata_i[0];
                default: ;
            endcase
        end
    end

    // a set in the same cycle as a clearing read wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (ovf) begin
            flag_q <= 1'b1;
        end else if (csr_rd) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_o = flag_q & ie_q;

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            ADDR_CSR: begin
                bus_rdata_o[CSR_EXT]             = ext_sel_q;
                bus_rdata_o[CSR_CODE +: CODE_W]  = code_q;
                bus_rdata_o[CSR_RUN]             = run_q;
                bus_rdata_o[CSR_IE]              = ie_q;
                bus_rdata_o[CSR_FLAG]            = flag_q;
            end
            ADDR_CNT: bus_rdata_o    = cnt;
            ADDR_ARR: bus_rdata_o    = reload_q;
            ADDR_CMP: bus_rdata_o    = cmp_q;
            ADDR_CFG: bus_rdata_o[0] = pol_q;
            default:  bus_rdata_o    = '0;
        endcase
    end

    art_tick_gen #(
        .PRE_W (PRE_W),
        .CODE_W(CODE_W),
        .SYNC_N(SYNC_N)
    ) u_tick (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ext_clk_i(ext_clk_i),
        .sel_ext_i(ext_sel_q),
        .code_i   (code_q),
        .run_i    (run_q),
        .clear_i  (force_ld),
        .tick_o   (tick)
    );

    art_counter #(
        .W(CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .load_i   (force_ld),
        .reload_i (reload_q),
        .wr_i     (cnt_wr),
        .wr_data_i(bus_wdata_i),
        .cnt_o    (cnt),
        .step_o   (step),
        .ovf_o    (ovf)
    );

    art_pwm_fsm #(
        .W(CNT_W)
    ) u_pwm (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .step_i(step),
        .ovf_i (ovf),
        .cnt_i (cnt),
        .cmp_i (cmp_q),
        .pol_i (pol_q),
        .pwm_o (pwm_o)
    );

    p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf |=> flag_q);

    p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_rd && !ovf) |=> !flag_q);

    p_force_no_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_ld |-> !ovf);

endmodule

// File: tb/art_pwm_timer_tb.sv
module art_pwm_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       pwm;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    art_pwm_timer u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ext_clk_i  (ext_clk),
        .bus_addr_i (addr),
        .bus_wr_i   (wr),
        .bus_rd_i   (rd),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq),
        .pwm_o      (pwm)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1;
        d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic ext_edges(input int k);
        for (int i = 0; i < k; i++) begin
            ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int rl[5];
        int cv[6];
        rl = '{0, 8'h80, 8'hF0, 8'hFE, 8'hFF};
        cv = '{0, 8'hE0, 8'hF0, 8'hF1, 8'hF8, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            peek(3'(a), d);
            check("R1", "reset register", int'(d), 0);
        end
        check("R1", "reset pwm", int'(pwm), 0);
        check("R1", "reset irq", int'(irq), 0);

        // R8 idle output before first overflow
        bus_write(3'd2, 8'h00);
        bus_write(3'd0, 8'h0C);
        for (int j = 0; j < 20; j++) begin
            check("R8", "idle pwm", int'(pwm), 0);
            @(negedge clk);
        end

        // R2 / R6 / R5 sweep of reload values and divide codes
        foreach (rl[k]) begin
            for (int n = 0; n < 8; n++) begin
                int p;
                int jmax;
                p = 256 - rl[k];
                jmax = 20 << n;
                bus_write(3'd0, 8'h00);
                bus_read(3'd0, d);
                bus_write(3'd2, 8'(rl[k]));
                bus_write(3'd0, 8'h0C | 8'(n << 4));
                for (int j = 0; j <= jmax; j++) begin
                    if (j > 0) @(negedge clk);
                    peek(3'd1, d);
                    check((j >> n) >= p ? "R6" : "R2", "count", int'(d), rl[k] + ((j >> n) % p));
                end
                peek(3'd0, d);
                // R5: force bit reads 0; R7 flag follows overflow
                check("R5", "csr readback", int'(d), (n << 4) | 8 | (((jmax >> n) >= p) ? 1 : 0));
            end
        end

        // R4 freeze with run enable cleared
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'h00);
        bus_write(3'd0, 8'h1C);
        repeat (10) @(negedge clk);
        bus_write(3'd0, 8'h10);
        peek(3'd1, d);
        check("R4", "count at stop", int'(d), 6);
        repeat (20) @(negedge clk);
        peek(3'd1, d);
        check("R4", "count frozen", int'(d), 6);

        // R9 software count write while running
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d);
        bus_write(3'd2, 8'h40);
        bus_write(3'd0, 8'h0C);
        repeat (5) @(negedge clk);
        bus_write(3'd1, 8'hFE);
        peek(3'd1, d);
        check("R9", "written count", int'(d), 8'hFE);
        @(negedge clk);
        peek(3'd1, d);
        check("R9", "step after write", int'(d), 8'hFF);
        @(negedge clk);
        peek(3'd1, d);
        check("R9", "reload after write", int'(d), 8'h40);

        // R7 flag, interrupt and same-cycle read
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, d);
        bus_write(3'd2, 8'hF0);
        bus_write(3'd0, 8'h0E);
        repeat (15) @(negedge clk);
        peek(3'd0, d);
        check("R7", "flag before overflow", int'(d[0]), 0);
        check("R7", "irq before overflow", int'(irq), 0);
        @(negedge clk);
        check("R7", "irq on overflow", int'(irq), 1);
        bus_read(3'd0, d);
        check("R7", "flag read", int'(d[0]), 1);
        peek(3'd0, d);
        check("R7", "flag cleared by read", int'(d[0]), 0);
        check("R7", "irq cleared", int'(irq), 0);
        repeat (14) @(negedge clk);
        bus_read(3'd0, d);
        peek(3'd0, d);
        check("R7", "flag kept on read at overflow", int'(d[0]), 1);
        bus_write(3'd0, 8'h08);
        check("R7", "irq masked", int'(irq), 0);
        peek(3'd0, d);
        check("R7", "flag still set", int'(d[0]), 1);

        // R3 / R10 external clock
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'h00);
        bus_write(3'd0, 8'h9C);
        repeat (30) @(negedge clk);
        peek(3'd1, d);
        check("R3", "no count on idle ext", int'(d), 0);
        ext_edges(10);
        peek(3'd1, d);
        check("R10", "ext edges div2", int'(d), 5);
        bus_write(3'd0, 8'h8C);
        ext_edges(7);
        peek(3'd1, d);
        check("R10", "ext edges div1", int'(d), 7);

        // R8 PWM sweep
        for (int pol = 0; pol < 2; pol++) begin
            foreach (cv[c]) begin
                bus_write(3'd0, 8'h00);
                bus_write(3'd4, 8'(pol));
                bus_write(3'd3, 8'(cv[c]));
                bus_write(3'd2, 8'hF0);
                bus_write(3'd0, 8'h0C);
                repeat (16) @(negedge clk);
                for (int j = 16; j <= 48; j++) begin
                    int v;
                    int e;
                    v = 8'hF0 + (j % 16);
                    e = (cv[c] > 8'hF0 && v >= cv[c]) ? 1 - pol : pol;
                    check("R8", "pwm level", int'(pwm), e);
                    @(negedge clk);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule